// File: doc/BRIEF.md
# Sliding Stack Window Register File

This block holds the local registers of one instruction stream. Instead of a fixed bank of eight registers, the eight visible names are offsets below a movable pointer into a 64-word on-chip stack. Register Rn lives at physical word `pointer - n`, modulo the stack depth. An instruction reads two registers and writes one, all by window-relative number. At the end of the cycle it may then slide the window up or down. A procedure can therefore claim exactly as many fresh registers as it needs, rather than a fixed-size overlapping bank.

A call slides the window up by one and deposits the return address in the new R0. A return names how far above its return-address slot the window has grown. In the same cycle the block presents the saved address, and the pointer drops past that slot, back to its value before the call. Any move that would run the pointer above the top word or below the stack floor is refused. The pointer stays where it is, and a one-cycle fault flag is raised, ready to be turned into an automatic interrupt by the surrounding stream logic.

Top module: `swin_regfile`

## Requirements
- R1: After reset the pointer is 0 (the stack floor, the empty position), every stack word reads as 0, and both fault flags are low.
- R2: A read of register n (0..7) returns the word at physical address (pointer - n) mod 64, and a write of register n stores `wr_data_i` at that same address at the clock edge; the pointer used is the value before any move requested in the same cycle.
- R3: When the write port targets the same physical word as a read port in the same cycle, that read port returns the data being written (write-first).
- R4: Operation code 1 (increment) raises the pointer by one at the clock edge, so the old Rk is afterwards read as R(k+1); codes 0, 5, 6 and 7 leave the pointer unchanged.
- R5: Operation code 2 (decrement) lowers the pointer by one at the clock edge.
- R6: Operation code 3 (call) raises the pointer by one and stores `call_addr_i` in the word that becomes the new R0.
- R7: Operation code 4 (return) with offset k (0..7) shows the word at (pointer - k) on `ret_data_o` during that cycle and lowers the pointer by k+1 at the clock edge.
- R8: An increment or call issued while the pointer is 63 is refused: the pointer holds, the call performs no store, and `ovf_o` is high for the following cycle.
- R9: A decrement, or a return with offset k, that would take the pointer below 0 is refused: the pointer holds and `unf_o` is high for the following cycle.
- R10: Address translation wraps modulo 64, so with pointer p < n register Rn refers to word p - n + 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Pointer operation: 0 none, 1 increment, 2 decrement, 3 call, 4 return |
| ret_ofs_i | input | 3 | Return offset k: distance from R0 down to the return-address slot |
| call_addr_i | input | 16 | Return address stored by a call |
| wr_en_i | input | 1 | Write enable for the register write port |
| wr_idx_i | input | 3 | Window-relative register written |
| wr_data_i | input | 16 | Write data |
| rd_a_idx_i | input | 3 | Window-relative register for read port A |
| rd_a_data_o | output | 16 | Read port A data |
| rd_b_idx_i | input | 3 | Window-relative register for read port B |
| rd_b_data_o | output | 16 | Read port B data |
| ret_data_o | output | 16 | Word in the return-address slot named by `ret_ofs_i` |
| awp_o | output | 6 | Current window pointer |
| ovf_o | output | 1 | A move past the top was refused in the previous cycle |
| unf_o | output | 1 | A move below the floor was refused in the previous cycle |

## Verification
The window is first grown one step at a time while R0 is written on every step. Reading R1 and R2 on those steps separates a correct renaming from an off-by-one translation. A call followed by three local increments and a return with offset 3 checks that the return slot and the unwound pointer line up, which a return decrementing by k instead of k+1 would miss. Both pointer limits are driven: the pointer is walked down to the floor and then up to 63. A refused call is then followed by a walk back down, and the word the call would have wrapped onto is read to show that it was left untouched. Same-cycle write and read of one register, and reads below pointer 7 that wrap to the top of the stack, cover the bypass and the modulo translation.

// File: rtl/swin_pkg.sv
package swin_pkg;

    // Window pointer operation codes (R4..R7)
    typedef enum logic [2:0] {
        WOP_NONE = 3'd0,
        WOP_INC  = 3'd1,
        WOP_DEC  = 3'd2,
        WOP_CALL = 3'd3,
        WOP_RET  = 3'd4
    } win_op_e;

endpackage

// File: rtl/swin_xlate.sv
// Window-relative register number to physical stack address.
module swin_xlate #(
    parameter int AW = 6,
    parameter int RW = 3
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [RW-1:0] idx_i,
    output logic [AW-1:0] phys_o
);
    localparam int PADW = AW - RW;

    // Rn sits n words below the pointer; the subtraction wraps (R10)
    always_comb begin
        phys_o = ptr_i - {{PADW{1'b0}}, idx_i};
    end
endmodule

// File: rtl/swin_ptr.sv
// Window pointer register with bounds checking ahead of commit.
module swin_ptr
    import swin_pkg::*;
#(
    parameter int AW    = 6,
    parameter int RW    = 3,
    parameter int FLOOR = 0,
    parameter int TOP   = 63
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [2:0]    op_i,
    input  logic [RW-1:0] ofs_i,
    output logic [AW-1:0] ptr_o,
    output logic          push_en_o,
    output logic [AW-1:0] push_addr_o,
    output logic          ovf_o,
    output logic          unf_o
);
    localparam int          PADW    = AW + 1 - RW;
    localparam logic [AW:0] TOP_W   = (AW+1)'(TOP);
    localparam logic [AW:0] FLOOR_W = (AW+1)'(FLOOR);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          ovf;
        logic          unf;
    } ptr_st_t;

    ptr_st_t     st_d, st_q;
    win_op_e     op;
    logic [AW:0] ptr_w;
    logic [AW:0] drop;
    logic        going_up;
    logic        going_down;
    logic        hit_top;
    logic        hit_floor;

    always_comb begin
        op         = win_op_e'(op_i);
        ptr_w      = {1'b0, st_q.ptr};
        going_up   = (op == WOP_INC) || (op == WOP_CALL);
        going_down = (op == WOP_DEC) || (op == WOP_RET);
        // amount removed: one for a decrement, k+1 for a return
        if (op == WOP_RET) begin
            drop = {{PADW{1'b0}}, ofs_i} + (AW+1)'(1);
        end else begin
            drop = (AW+1)'(1);
        end
        hit_top   = going_up && (ptr_w + (AW+1)'(1) > TOP_W);
        hit_floor = going_down && (ptr_w < FLOOR_W + drop);

        st_d     = st_q;
        st_d.ovf = hit_top;
        st_d.unf = hit_floor;
        if (going_up && !hit_top) begin
            st_d.ptr = st_q.ptr + AW'(1);
        end else if (going_down && !hit_floor) begin
            st_d.ptr = st_q.ptr - drop[AW-1:0];
        end

        push_en_o   = (op == WOP_CALL) && !hit_top;
        push_addr_o = st_q.ptr + AW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{ptr: AW'(FLOOR), ovf: 1'b0, unf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;
    assign ovf_o = st_q.ovf;
    assign unf_o = st_q.unf;
endmodule

// File: rtl/swin_store.sv
// Physical stack storage: one register write port, one push port,
// NRP combinational read ports with write-first bypass.
module swin_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    parameter int NRP   = 3,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  logic [AW-1:0]             wr_addr_i,
    input  logic [WIDTH-1:0]          wr_data_i,
    input  logic                      push_en_i,
    input  logic [AW-1:0]             push_addr_i,
    input  logic [WIDTH-1:0]          push_data_i,
    input  logic [NRP-1:0][AW-1:0]    rd_addr_i,
    output logic [NRP-1:0][WIDTH-1:0] rd_data_o
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            mem_d[wr_addr_i] = wr_data_i;
        end
        // a push never aliases the register write (it lands above R0)
        if (push_en_i) begin
            mem_d[push_addr_i] = push_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < NRP; g++) begin : g_rd
        always_comb begin
            if (wr_en_i && (wr_addr_i == rd_addr_i[g])) begin
                rd_data_o[g] = wr_data_i;
            end else begin
                rd_data_o[g] = mem_q[rd_addr_i[g]];
            end
        end
    end
endmodule

// File: rtl/swin_regfile.sv
// Sliding stack window register file: top level.
module swin_regfile #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    parameter int NREGS = 8,
    parameter int FLOOR = 0
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [2:0]                 op_i,
    input  logic [$clog2(NREGS)-1:0]   ret_ofs_i,
    input  logic [WIDTH-1:0]           call_addr_i,
    input  logic                       wr_en_i,
    input  logic [$clog2(NREGS)-1:0]   wr_idx_i,
    input  logic [WIDTH-1:0]           wr_data_i,
    input  logic [$clog2(NREGS)-1:0]   rd_a_idx_i,
    output logic [WIDTH-1:0]           rd_a_data_o,
    input  logic [$clog2(NREGS)-1:0]   rd_b_idx_i,
    output logic [WIDTH-1:0]           rd_b_data_o,
    output logic [WIDTH-1:0]           ret_data_o,
    output logic [$clog2(DEPTH)-1:0]   awp_o,
    output logic                       ovf_o,
    output logic                       unf_o
);
    localparam int AW   = $clog2(DEPTH);
    localparam int RW   = $clog2(NREGS);
    localparam int TOP  = DEPTH - 1;
    localparam int NRP  = 3;         // port A, port B, return slot
    localparam int NLK  = NRP + 1;   // plus the write port

    logic [AW-1:0]               ptr;
    logic                        push_en;
    logic [AW-1:0]               push_addr;
    logic [NLK-1:0][RW-1:0]      lk_idx;
    logic [NLK-1:0][AW-1:0]      lk_phys;
    logic [NRP-1:0][AW-1:0]      rd_addr;
    logic [NRP-1:0][WIDTH-1:0]   rd_data;

    swin_ptr #(
        .AW    (AW),
        .RW    (RW),
        .FLOOR (FLOOR),
        .TOP   (TOP)
    ) u_ptr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_i        (op_i),
        .ofs_i       (ret_ofs_i),
        .ptr_o       (ptr),
        .push_en_o   (push_en),
        .push_addr_o (push_addr),
        .ovf_o       (ovf_o),
        .unf_o       (unf_o)
    );

    assign lk_idx[0] = rd_a_idx_i;
    assign lk_idx[1] = rd_b_idx_i;
    assign lk_idx[2] = ret_ofs_i;
    assign lk_idx[3] = wr_idx_i;

    for (genvar g = 0; g < NLK; g++) begin : g_xl
        swin_xlate #(
            .AW (AW),
            .RW (RW)
        ) u_xl (
            .ptr_i  (ptr),
            .idx_i  (lk_idx[g]),
            .phys_o (lk_phys[g])
        );
    end

    for (genvar g = 0; g < NRP; g++) begin : g_ra
        assign rd_addr[g] = lk_phys[g];
    end

    swin_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .NRP   (NRP),
        .AW    (AW)
    ) u_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (lk_phys[3]),
        .wr_data_i   (wr_data_i),
        .push_en_i   (push_en),
        .push_addr_i (push_addr),
        .push_data_i (call_addr_i),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data)
    );

    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];
    assign ret_data_o  = rd_data[2];
    assign awp_o       = ptr;
endmodule

// File: rtl/swin_regfile_chk.sv
module swin_regfile_chk
    import swin_pkg::*;
#(
    parameter int AW    = 6,
    parameter int RW    = 3,
    parameter int WIDTH = 16,
    parameter int TOP   = 63,
    parameter int FLOOR = 0
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [2:0]       op_i,
    input logic [RW-1:0]    ret_ofs_i,
    input logic             wr_en_i,
    input logic [RW-1:0]    wr_idx_i,
    input logic [WIDTH-1:0] wr_data_i,
    input logic [RW-1:0]    rd_a_idx_i,
    input logic [WIDTH-1:0] rd_a_data_o,
    input logic [RW-1:0]    rd_b_idx_i,
    input logic [WIDTH-1:0] rd_b_data_o,
    input logic [AW-1:0]    awp_o,
    input logic             ovf_o,
    input logic             unf_o
);
    localparam logic [AW:0] TOP_W   = (AW+1)'(TOP);
    localparam logic [AW:0] FLOOR_W = (AW+1)'(FLOOR);

    logic [AW:0] ptr_w;
    logic [AW:0] ret_drop;
    assign ptr_w    = {1'b0, awp_o};
    assign ret_drop = {{(AW+1-RW){1'b0}}, ret_ofs_i} + (AW+1)'(1);

    assert_bypass_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_idx_i == rd_a_idx_i) |-> rd_a_data_o == wr_data_i);

    assert_bypass_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_idx_i == rd_b_idx_i) |-> rd_b_data_o == wr_data_i);

    assert_inc_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == WOP_INC && ptr_w < TOP_W) |=> awp_o == $past(awp_o) + AW'(1));

    assert_dec_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == WOP_DEC && ptr_w > FLOOR_W) |=> awp_o == $past(awp_o) - AW'(1));

    assert_call_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == WOP_CALL && ptr_w < TOP_W) |=> awp_o == $past(awp_o) + AW'(1));

    assert_ret_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == WOP_RET && ptr_w >= FLOOR_W + ret_drop)
        |=> {1'b0, awp_o} == $past(ptr_w) - $past(ret_drop));

    assert_no_overflow_move_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> $stable(awp_o));

    assert_ovf_raise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((op_i == WOP_INC || op_i == WOP_CALL) && ptr_w == TOP_W) |=> ovf_o);

    assert_no_underflow_move_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unf_o |-> $stable(awp_o));

    assert_flags_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ovf_o && unf_o));
endmodule

bind swin_regfile swin_regfile_chk #(
    .AW    ($clog2(DEPTH)),
    .RW    ($clog2(NREGS)),
    .WIDTH (WIDTH),
    .TOP   (DEPTH - 1),
    .FLOOR (FLOOR)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op_i),
    .ret_ofs_i   (ret_ofs_i),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .rd_a_idx_i  (rd_a_idx_i),
    .rd_a_data_o (rd_a_data_o),
    .rd_b_idx_i  (rd_b_idx_i),
    .rd_b_data_o (rd_b_data_o),
    .awp_o       (awp_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o)
);

// File: tb/swin_regfile_bench.sv
module swin_regfile_bench;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [2:0]  op_i = '0;
    logic [2:0]  ret_ofs_i = '0;
    logic [15:0] call_addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_idx_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [2:0]  rd_a_idx_i = '0;
    logic [15:0] rd_a_data_o;
    logic [2:0]  rd_b_idx_i = '0;
    logic [15:0] rd_b_data_o;
    logic [15:0] ret_data_o;
    logic [5:0]  awp_o;
    logic        ovf_o;
    logic        unf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model
    int m_mem [64];
    int m_awp = 0;
    int m_ovf = 0;
    int m_unf = 0;

    always #10 clk_i = ~clk_i;   // 50 MHz

    swin_regfile u_swin_regfile (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_i        (op_i),
        .ret_ofs_i   (ret_ofs_i),
        .call_addr_i (call_addr_i),
        .wr_en_i     (wr_en_i),
        .wr_idx_i    (wr_idx_i),
        .wr_data_i   (wr_data_i),
        .rd_a_idx_i  (rd_a_idx_i),
        .rd_a_data_o (rd_a_data_o),
        .rd_b_idx_i  (rd_b_idx_i),
        .rd_b_data_o (rd_b_data_o),
        .ret_data_o  (ret_data_o),
        .awp_o       (awp_o),
        .ovf_o       (ovf_o),
        .unf_o       (unf_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int phys(input int n);
        return (m_awp - n) & 63;
    endfunction

    function automatic int rd_model(input int n, input bit we, input int wi, input int wd);
        if (we && phys(wi) == phys(n)) return wd;
        return m_mem[phys(n)];
    endfunction

    // one instruction cycle: drive, check reads, clock, check pointer state
    task automatic step(input string tag, input int op, input int ofs,
                        input int ra, input int rb, input bit we,
                        input int wi, input int wd, input int cad);
        int d;
        @(negedge clk_i);
        op_i = 3'(op); ret_ofs_i = 3'(ofs); rd_a_idx_i = 3'(ra); rd_b_idx_i = 3'(rb);
        wr_en_i = we; wr_idx_i = 3'(wi); wr_data_i = 16'(wd); call_addr_i = 16'(cad);
        #5;
        check(tag, "rd_a", int'(rd_a_data_o), rd_model(ra, we, wi, wd));
        check(tag, "rd_b", int'(rd_b_data_o), rd_model(rb, we, wi, wd));
        check(tag, "ret_data", int'(ret_data_o), rd_model(ofs, we, wi, wd));
        @(posedge clk_i);
        if (we) m_mem[phys(wi)] = wd & 16'hFFFF;
        m_ovf = 0; m_unf = 0;
        case (op)
            1, 3: begin
                if (m_awp + 1 > 63) m_ovf = 1;
                else begin
                    m_awp++;
                    if (op == 3) m_mem[m_awp] = cad & 16'hFFFF;
                end
            end
            2, 4: begin
                d = (op == 4) ? ofs + 1 : 1;
                if (m_awp - d < 0) m_unf = 1;
                else m_awp -= d;
            end
            default: ;
        endcase
        #1;
        check(tag, "awp", int'(awp_o), m_awp);
        check(tag, "ovf", int'(ovf_o), m_ovf);
        check(tag, "unf", int'(unf_o), m_unf);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = 0;
        repeat (3) @(posedge clk_i);
        rst_ni = 1'b1;
        #1;
        // R1: reset state
        check("R1", "awp", int'(awp_o), 0);
        check("R1", "ovf", int'(ovf_o), 0);
        check("R1", "unf", int'(unf_o), 0);
        check("R1", "rd_a", int'(rd_a_data_o), 0);

        // R4: grow window, writing R0 each step, reading R1/R2 (renaming)
        for (int i = 0; i < 10; i++) step("R4", 1, 0, 1, 2, 1, 0, 16'h100 + i, 0);
        step("R2", 0, 0, 3, 7, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 5, 1, 4, 16'h4444, 0);
        step("R2", 0, 0, 4, 1, 0, 0, 0, 0);
        // R3: write-first bypass on both ports
        step("R3", 0, 0, 2, 2, 1, 2, 16'hBEEF, 0);
        step("R3", 0, 0, 6, 2, 1, 6, 16'hCAFE, 0);
        // reserved codes act as no operation
        step("R4", 7, 0, 0, 1, 0, 0, 0, 0);
        step("R4", 5, 0, 0, 1, 0, 0, 0, 0);
        // R6: call then read new R0
        step("R6", 3, 0, 0, 1, 0, 0, 0, 16'h1234);
        step("R6", 0, 0, 0, 1, 0, 0, 0, 0);
        // callee claims three locals, then returns with offset 3 (R7)
        for (int i = 0; i < 3; i++) step("R4", 1, 0, 0, 1, 1, 0, 16'h700 + i, 0);
        step("R7", 4, 3, 0, 3, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 1, 0, 0, 0, 0);
        // R5: walk down to the floor
        for (int i = 0; i < 12; i++) step("R5", 2, 0, 0, 1, 0, 0, 0, 0);
        // R9: refused moves below the floor
        step("R9", 2, 0, 0, 1, 0, 0, 0, 0);
        step("R9", 4, 2, 0, 1, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 1, 0, 0, 0, 0);
        // R10: wrapped translation at pointer 0
        step("R10", 0, 0, 3, 7, 1, 3, 16'h5A5A, 0);
        step("R10", 0, 5, 3, 1, 0, 0, 0, 0);
        // R8: climb to the top writing R0, then refused increment and call
        for (int i = 0; i < 63; i++) step("R4", 1, 0, 1, 7, 1, 0, 16'h2000 + i, 0);
        step("R8", 1, 0, 0, 1, 0, 0, 0, 0);
        step("R8", 3, 0, 0, 1, 0, 0, 0, 16'hDEAD);
        step("R8", 0, 0, 0, 1, 0, 0, 0, 0);
        // R7: return with maximal offset from the top
        step("R7", 4, 7, 7, 0, 0, 0, 0, 0);
        for (int i = 0; i < 55; i++) step("R5", 2, 0, 0, 1, 0, 0, 0, 0);
        // word 0 must not hold the refused call's address
        step("R8", 0, 0, 0, 1, 0, 0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule